// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, every cycle and without storage, where each operand consumer in a five-stage integer pipeline takes its value from. It looks at the source register numbers of the instruction in execute and the instruction in decode. It compares them with the destination numbers and write enables held in the two later pipeline registers: the execute/memory register, called the "memory stage" below, and the memory/writeback register, called the "writeback stage". From that comparison it produces mux selects. The datapath muxes, the register file and the ALU sit outside the block and follow these selects.

There are three groups of selects. Each of the two ALU operands gets a 2-bit select. Each operand of a decode-stage branch comparator gets a 1-bit select. The store-data input of data memory gets a 1-bit select, so that a load in writeback can hand its value straight to a store in the memory stage without a stall. All pins are plain control signals with no valid/ready handshake, because no data passes through the block. Each select can change only when the inputs change, and it settles within the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Each ALU operand select is 2'b00 to take the register-read value, 2'b10 to take the memory-stage result and 2'b01 to take the writeback-stage result; 2'b11 never appears.
- R2: An ALU operand select points at a stage only when that stage's write enable is 1 and its destination number equals the operand's source number.
- R3: A destination number of 0 never causes any select (ALU, comparator or store data) to leave its default of 0.
- R4: When the memory stage and the writeback stage both write the same nonzero register that an ALU operand reads, the select is 2'b10. The select is 2'b01 only if the memory stage misses or does not write.
- R5: The two ALU operand selects are computed independently: operand B follows the same rules from its own source number, whatever operand A does.
- R6: A comparator select is 1 exactly when the decode-stage branch flag is 1, the memory stage writes a nonzero register, and that register equals the comparator operand's source number.
- R7: A comparator select never depends on the writeback stage; it stays 0 when only the writeback stage matches, and 0 whenever the branch flag is 0.
- R8: The store-data select is 1 exactly when the memory-stage instruction is a store, the writeback-stage instruction is a load with its write enable set, its destination is nonzero, and that destination equals the store's data register number.
- R9: All selects are combinational: a change on the inputs shows on the selects before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register number of the instruction in execute |
| ex_src_b | input | REG_W | Second source register number of the instruction in execute |
| id_src_a | input | REG_W | First source register number of the instruction in decode |
| id_src_b | input | REG_W | Second source register number of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a branch that compares in decode |
| mem_dst | input | REG_W | Destination register number held in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register number held in the writeback stage |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_store_src | input | REG_W | Register number supplying the store data in the memory stage |
| alu_sel_a | output | 2 | Bypass select for ALU operand A |
| alu_sel_b | output | 2 | Bypass select for ALU operand B |
| cmp_sel_a | output | 1 | Comparator operand A takes the memory-stage result |
| cmp_sel_b | output | 1 | Comparator operand B takes the memory-stage result |
| st_data_sel | output | 1 | Store data takes the writeback-stage load value |

## Verification
The block holds no state, so any fault in its match or priority logic shows at the select pins in the same cycle as the input pattern that exposes it. There is no delay, and no earlier history is needed to reach the fault. The harmful patterns are specific ones: both later stages writing the same register, either stage naming register 0, and a writeback-only match during a branch. Register numbers are drawn from a set that includes 0, two small values and the all-ones value, and every combination of that set is swept with both write enables. This covers back-to-back writes to one register, and writes to register 0, in every pairing.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  // ALU operand source; the bit positions are decoded by the datapath mux
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMSTG  = 2'b10,
    SRC_WBSTG   = 2'b01
  } alu_src_e;

  localparam int unsigned N_ALU_OPS = 2;
  localparam int unsigned N_CMP_OPS = 2;

endpackage

// File: rtl/fwd_hit.sv
`timescale 1ns/1ps
// One producer/consumer match: the producer writes, is not register 0,
// and names the consumer's source.
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr_en,
  output logic             hit
);
  localparam logic [REG_W-1:0] HARD_ZERO = '0;

  always_comb begin
    hit = wr_en && (dst != HARD_ZERO) && (dst == src);
  end
endmodule

// File: rtl/fwd_alu_sel.sv
`timescale 1ns/1ps
// Select for one ALU operand; the younger producer (memory stage) wins.
module fwd_alu_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output alu_src_e         sel
);
  logic mem_hit;
  logic wb_hit;

  fwd_hit #(.REG_W(REG_W)) u_mem_hit (
    .src(src), .dst(mem_dst), .wr_en(mem_wr_en), .hit(mem_hit)
  );

  fwd_hit #(.REG_W(REG_W)) u_wb_hit (
    .src(src), .dst(wb_dst), .wr_en(wb_wr_en), .hit(wb_hit)
  );

  always_comb begin
    if (mem_hit)     sel = SRC_MEMSTG;
    else if (wb_hit) sel = SRC_WBSTG;
    else             sel = SRC_REGFILE;
  end
endmodule

// File: rtl/fwd_cmp_sel.sv
`timescale 1ns/1ps
// Select for one decode-stage comparator operand. Only the memory stage
// feeds it; a writeback value reaches decode through the register file.
module fwd_cmp_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic             branch,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  output logic             sel
);
  logic mem_hit;

  fwd_hit #(.REG_W(REG_W)) u_mem_hit (
    .src(src), .dst(mem_dst), .wr_en(mem_wr_en), .hit(mem_hit)
  );

  always_comb begin
    sel = branch && mem_hit;
  end
endmodule

// File: rtl/fwd_store_sel.sv
`timescale 1ns/1ps
// Load in writeback feeding the data of a store in the memory stage.
module fwd_store_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic             mem_store,
  input  logic [REG_W-1:0] store_src,
  input  logic             wb_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output logic             sel
);
  logic wb_hit;

  fwd_hit #(.REG_W(REG_W)) u_wb_hit (
    .src(store_src), .dst(wb_dst), .wr_en(wb_wr_en), .hit(wb_hit)
  );

  always_comb begin
    sel = mem_store && wb_load && wb_hit;
  end
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_branch,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic             wb_load,
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_store_src,
  output logic [1:0]       alu_sel_a,
  output logic [1:0]       alu_sel_b,
  output logic             cmp_sel_a,
  output logic             cmp_sel_b,
  output logic             st_data_sel
);
  logic [N_ALU_OPS-1:0][REG_W-1:0] ex_src;
  logic [N_CMP_OPS-1:0][REG_W-1:0] id_src;
  alu_src_e                        alu_sel [N_ALU_OPS];
  logic [N_CMP_OPS-1:0]            cmp_sel;

  assign ex_src = {ex_src_b, ex_src_a};
  assign id_src = {id_src_b, id_src_a};

  for (genvar i = 0; i < N_ALU_OPS; i++) begin : g_alu
    fwd_alu_sel #(.REG_W(REG_W)) u_alu_sel (
      .src       (ex_src[i]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (alu_sel[i])
    );
  end

  for (genvar i = 0; i < N_CMP_OPS; i++) begin : g_cmp
    fwd_cmp_sel #(.REG_W(REG_W)) u_cmp_sel (
      .branch    (id_branch),
      .src       (id_src[i]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .sel       (cmp_sel[i])
    );
  end

  fwd_store_sel #(.REG_W(REG_W)) u_store_sel (
    .mem_store (mem_store),
    .store_src (mem_store_src),
    .wb_load   (wb_load),
    .wb_dst    (wb_dst),
    .wb_wr_en  (wb_wr_en),
    .sel       (st_data_sel)
  );

  assign alu_sel_a = alu_sel[0];
  assign alu_sel_b = alu_sel[1];
  assign cmp_sel_a = cmp_sel[0];
  assign cmp_sel_b = cmp_sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
`timescale 1ns/1ps
module fwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] ex_src_a,
  input logic [REG_W-1:0] ex_src_b,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_branch,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr_en,
  input logic             wb_load,
  input logic             mem_store,
  input logic [REG_W-1:0] mem_store_src,
  input logic [1:0]       alu_sel_a,
  input logic [1:0]       alu_sel_b,
  input logic             cmp_sel_a,
  input logic             cmp_sel_b,
  input logic             st_data_sel
);
  localparam logic [REG_W-1:0] R_ZERO = '0;

  logic known;
  assign known = !$isunknown({ex_src_a, ex_src_b, id_src_a, id_src_b, id_branch,
                               mem_dst, mem_wr_en, wb_dst, wb_wr_en, wb_load,
                               mem_store, mem_store_src, alu_sel_a, alu_sel_b,
                               cmp_sel_a, cmp_sel_b, st_data_sel});

  always_comb begin
    if (known) begin
      // R1: the unused code never appears
      a_r1_no_code3_a: assert (alu_sel_a != 2'b11);
      a_r1_no_code3_b: assert (alu_sel_b != 2'b11);
      // R2: nothing writing means no bypass anywhere on the ALU
      a_r2_idle_alu: assert (mem_wr_en || wb_wr_en || (alu_sel_a == 2'b00 && alu_sel_b == 2'b00));
      // R3: both destinations zero leaves every select at default
      a_r3_zero_dst: assert (mem_dst != R_ZERO || wb_dst != R_ZERO ||
                             (alu_sel_a == 2'b00 && alu_sel_b == 2'b00 &&
                              !cmp_sel_a && !cmp_sel_b && !st_data_sel));
      // R4: a writing, matching memory stage always wins
      a_r4_mem_first_a: assert (!(mem_wr_en && mem_dst != R_ZERO && mem_dst == ex_src_a) ||
                                alu_sel_a == 2'b10);
      // R5: operand B obeys the same priority on its own source
      a_r5_mem_first_b: assert (!(mem_wr_en && mem_dst != R_ZERO && mem_dst == ex_src_b) ||
                                alu_sel_b == 2'b10);
      // R6: comparator bypass only with a writing memory stage on a branch
      a_r6_cmp_needs_mem: assert (!(cmp_sel_a || cmp_sel_b) || (id_branch && mem_wr_en));
      // R7: a writeback-only match leaves the comparator alone
      a_r7_cmp_no_wb: assert (mem_wr_en || (!cmp_sel_a && !cmp_sel_b));
      // R8: store-data bypass only for a load feeding a store
      a_r8_store_pair: assert (!st_data_sel || (mem_store && wb_load && wb_wr_en &&
                                                wb_dst == mem_store_src));
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;
  localparam int unsigned W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b;
  logic         id_branch;
  logic [W-1:0] mem_dst, wb_dst, mem_store_src;
  logic         mem_wr_en, wb_wr_en, wb_load, mem_store;
  logic [1:0]   alu_sel_a, alu_sel_b;
  logic         cmp_sel_a, cmp_sel_b, st_data_sel;

  int n_chk  = 0;
  int n_fail = 0;

  fwd_unit #(.REG_W(W)) i_fwd_unit (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_branch(id_branch),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .wb_load(wb_load),
    .mem_store(mem_store), .mem_store_src(mem_store_src),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .cmp_sel_a(cmp_sel_a), .cmp_sel_b(cmp_sel_b), .st_data_sel(st_data_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // register numbers: zero, two small ones, all ones
  function automatic logic [W-1:0] pick(input int k);
    case (k & 3)
      0: pick = '0;
      1: pick = W'(1);
      2: pick = W'(2);
      default: pick = '1;
    endcase
  endfunction

  function automatic logic [1:0] exp_alu(input logic [W-1:0] s, input logic [W-1:0] md,
                                         input logic mw, input logic [W-1:0] wd,
                                         input logic ww);
    if (mw && md != 0 && md == s)      exp_alu = 2'b10;
    else if (ww && wd != 0 && wd == s) exp_alu = 2'b01;
    else                               exp_alu = 2'b00;
  endfunction

  task automatic clear_inputs();
    ex_src_a = '0; ex_src_b = '0; id_src_a = '0; id_src_b = '0; id_branch = 1'b0;
    mem_dst = '0; wb_dst = '0; mem_store_src = '0;
    mem_wr_en = 1'b0; wb_wr_en = 1'b0; wb_load = 1'b0; mem_store = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: nothing writes, everything default (R2, R3)
    chk("R2", "reset alu_a", alu_sel_a, 2'b00);
    chk("R2", "reset alu_b", alu_sel_b, 2'b00);
    chk("R3", "reset cmp/st", {cmp_sel_a | cmp_sel_b, st_data_sel}, 2'b00);
    rst = 1'b0;

    // R1 encodings
    @(posedge clk); ex_src_a = W'(3); mem_dst = W'(3); mem_wr_en = 1'b1;
    @(negedge clk); chk("R1", "mem code", alu_sel_a, 2'b10);
    @(posedge clk); mem_wr_en = 1'b0; wb_dst = W'(3); wb_wr_en = 1'b1;
    @(negedge clk); chk("R1", "wb code", alu_sel_a, 2'b01);

    // ALU sweep
    for (int v = 0; v < 1024; v++) begin
      @(posedge clk);
      clear_inputs();
      ex_src_a  = pick(v);
      ex_src_b  = pick(v >> 2);
      mem_dst   = pick(v >> 4);
      wb_dst    = pick(v >> 6);
      mem_wr_en = v[8];
      wb_wr_en  = v[9];
      @(negedge clk);
      begin
        string tag;
        if (mem_wr_en && wb_wr_en && mem_dst == wb_dst && mem_dst == ex_src_a && mem_dst != 0)
          tag = "R4";
        else if (ex_src_a == 0) tag = "R3";
        else tag = "R2";
        chk(tag, "alu_a", alu_sel_a, exp_alu(ex_src_a, mem_dst, mem_wr_en, wb_dst, wb_wr_en));
        chk("R5", "alu_b", alu_sel_b, exp_alu(ex_src_b, mem_dst, mem_wr_en, wb_dst, wb_wr_en));
      end
    end

    // comparator sweep
    for (int v = 0; v < 2048; v++) begin
      @(posedge clk);
      clear_inputs();
      id_src_a  = pick(v);
      id_src_b  = pick(v >> 2);
      mem_dst   = pick(v >> 4);
      wb_dst    = pick(v >> 6);
      mem_wr_en = v[8];
      wb_wr_en  = v[9];
      id_branch = v[10];
      @(negedge clk);
      begin
        string tag;
        logic ea, eb;
        ea = id_branch && mem_wr_en && mem_dst != 0 && mem_dst == id_src_a;
        eb = id_branch && mem_wr_en && mem_dst != 0 && mem_dst == id_src_b;
        tag = (wb_wr_en && wb_dst != 0 && wb_dst == id_src_a) ? "R7" : "R6";
        chk(tag, "cmp_a", {1'b0, cmp_sel_a}, {1'b0, ea});
        chk("R6", "cmp_b", {1'b0, cmp_sel_b}, {1'b0, eb});
      end
    end

    // store-data sweep
    for (int v = 0; v < 128; v++) begin
      @(posedge clk);
      clear_inputs();
      mem_store     = v[0];
      mem_store_src = pick(v >> 1);
      wb_load       = v[3];
      wb_dst        = pick(v >> 4);
      wb_wr_en      = v[6];
      @(negedge clk);
      begin
        logic es;
        es = mem_store && wb_load && wb_wr_en && wb_dst != 0 && wb_dst == mem_store_src;
        chk((wb_dst == 0) ? "R3" : "R8", "st_data", {1'b0, st_data_sel}, {1'b0, es});
      end
    end

    // R9: change and observe between edges, no clock edge in between
    @(negedge clk);
    #0.5;
    clear_inputs();
    ex_src_b = W'(7); wb_dst = W'(7); wb_wr_en = 1'b1;
    #1;
    chk("R9", "same-cycle alu_b", alu_sel_b, 2'b01);
    mem_dst = W'(7); mem_wr_en = 1'b1;
    #1;
    chk("R9", "same-cycle alu_b prio", alu_sel_b, 2'b10);

    @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule